// File: doc/BRIEF.md
# Wide Status Register File

This block holds the wide status registers of a wide-datapath accelerator core. It has three registers of 256 bits each. A 2-bit index picks one of them. Reads are combinational and always show the committed contents. Writes are staged. A write lands in a per-register pending slot and becomes visible only when the core pulses commit. A pulse on abort discards every staged write, so a faulting or squashed instruction leaves no trace.

One of the three entries is a fixed random-value source. It reads as a constant nibble pattern spread over the full width, it never accepts a write, and it has a separate 32-bit view of its low word. For tracing, each register reports a pending flag together with its staged value. Index 3 has no register behind it. A write there raises a one-cycle error flag.

Top module: `wsr_file`

## Requirements
- R1: A synchronous active-high reset clears every stored value to zero, clears all pending state and drops the error flag. After reset, reads at indices 0 and 2 return zero and all pending flags are low.
- R2: The read port is combinational and returns committed values. Index 0 is the modulus register, index 1 is the random register and index 2 is the accumulator register.
- R3: A write at index 0 or 2 becomes pending. The read value does not change, `pend_flags[i]` goes high for index i, and the staged value appears on `pend_mod` or `pend_acc` from the next cycle. A pending output reads zero while its flag is low.
- R4: On commit, each register with a pending value loads it and clears its flag. A register with nothing pending keeps its value. A write in the same cycle as a commit stays pending after that commit.
- R5: Abort clears all pending flags and leaves the stored values unchanged. A write in the same cycle as an abort is dropped. When commit and abort are both high, abort wins.
- R6: Index 1 always reads as the nibble 4'h9 repeated across the full width. Writes to it are ignored, and `pend_flags[1]` never rises.
- R7: `rd_rnd32` always equals the low 32 bits of the random register, 32'h99999999.
- R8: A second write to a register that is already pending replaces the staged value.
- R9: Index 3 is illegal. A read there returns zero and a write there is dropped. `idx_err` is high for exactly the cycle after each such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 2 | Read index |
| rd_data | output | 256 | Committed value at rd_idx |
| rd_rnd32 | output | 32 | Low word of the random register |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 2 | Write index |
| wr_data | input | 256 | Write value |
| commit | input | 1 | Make pending writes visible |
| abort | input | 1 | Discard pending writes |
| pend_flags | output | 3 | Pending flag per index (bit i = index i) |
| pend_mod | output | 256 | Staged modulus value, zero if none |
| pend_acc | output | 256 | Staged accumulator value, zero if none |
| idx_err | output | 1 | Illegal-index write seen last cycle |

## Verification
The bench builds the block with its default 256-bit width and the 4'h9 fill nibble. At this width the constant pattern covers all 64 nibbles, so a fill error in any nibble shows on the read port. Full-width random data exposes any lane of a staged or committed value that is lost or swapped. Random commit/abort/write overlaps, including all three in one cycle, reach the priority corners next to the directed cases.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

    localparam int IDX_W    = 2;
    localparam int NUM_REGS = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_MOD = 2'd0,
        IDX_RND = 2'd1,
        IDX_ACC = 2'd2,
        IDX_BAD = 2'd3
    } wsr_idx_e;

    typedef struct packed {
        logic     en;
        wsr_idx_e idx;
    } wr_req_t;

    function automatic logic idx_legal(input wsr_idx_e idx);
        return idx != IDX_BAD;
    endfunction

    function automatic logic idx_writable(input int unsigned slot);
        return slot != int'(IDX_RND);
    endfunction

endpackage

// File: rtl/wsr_const_src.sv
module wsr_const_src #(
    parameter int          DATA_W = 256,
    parameter logic [3:0]  NIB    = 4'h9
) (
    output logic [DATA_W-1:0] value
);
    localparam int NIB_CNT = DATA_W / 4;

    for (genvar n = 0; n < NIB_CNT; n++) begin : g_nib
        assign value[n*4 +: 4] = NIB;
    end
endmodule

// File: rtl/wsr_slot.sv
module wsr_slot #(
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic              abort,
    output logic [DATA_W-1:0] cur_val,
    output logic              pend_vld,
    output logic [DATA_W-1:0] pend_val
);
    logic [DATA_W-1:0] stored_q;
    logic [DATA_W-1:0] staged_q;
    logic              staged_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored_q     <= '0;
            staged_q     <= '0;
            staged_vld_q <= 1'b0;
        end else if (abort) begin
            staged_vld_q <= 1'b0;
        end else begin
            if (commit && staged_vld_q) begin
                stored_q     <= staged_q;
                staged_vld_q <= 1'b0;
            end
            if (wr_hit) begin
                staged_q     <= wr_data;
                staged_vld_q <= 1'b1;
            end
        end
    end

    assign cur_val  = stored_q;
    assign pend_vld = staged_vld_q;
    assign pend_val = staged_vld_q ? staged_q : '0;

    // R5: abort leaves nothing pending
    p_abort_clears_r5: assert property (@(posedge clk) disable iff (rst)
        abort |=> !pend_vld);

    // R5: abort keeps stored contents
    p_abort_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        abort |=> $stable(cur_val));

    // R3: without commit the visible value does not move
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(cur_val));

    // R4: commit with pending data loads it
    p_commit_load_r4: assert property (@(posedge clk) disable iff (rst)
        (commit && !abort && pend_vld) |=> cur_val == $past(pend_val));

    // R3: a write makes the slot pending
    p_write_pends_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !abort) |=> pend_vld);
endmodule

// File: rtl/wsr_file.sv
module wsr_file
    import wsr_pkg::*;
#(
    parameter int         DATA_W  = 256,
    parameter logic [3:0] RND_NIB = 4'h9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [31:0]       rd_rnd32,
    input  logic              wr_en,
    input  logic [1:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic              abort,
    output logic [2:0]        pend_flags,
    output logic [DATA_W-1:0] pend_mod,
    output logic [DATA_W-1:0] pend_acc,
    output logic              idx_err
);
    localparam int LOW_W = (DATA_W < 32) ? DATA_W : 32;

    wr_req_t           req;
    logic [DATA_W-1:0] cur   [NUM_REGS];
    logic [DATA_W-1:0] pdata [NUM_REGS];
    logic              pvld  [NUM_REGS];
    logic              err_q;

    assign req.en  = wr_en;
    assign req.idx = wsr_idx_e'(wr_idx);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (idx_writable(i)) begin : g_rw
            wsr_slot #(.DATA_W(DATA_W)) i_slot (
                .clk      (clk),
                .rst      (rst),
                .wr_hit   (req.en && (req.idx == wsr_idx_e'(i))),
                .wr_data  (wr_data),
                .commit   (commit),
                .abort    (abort),
                .cur_val  (cur[i]),
                .pend_vld (pvld[i]),
                .pend_val (pdata[i])
            );
        end else begin : g_const
            wsr_const_src #(.DATA_W(DATA_W), .NIB(RND_NIB)) i_src (
                .value (cur[i])
            );
            assign pvld[i]  = 1'b0;
            assign pdata[i] = '0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (idx_legal(wsr_idx_e'(rd_idx))) begin
            rd_data = cur[rd_idx];
        end
    end

    always_comb begin
        rd_rnd32 = '0;
        rd_rnd32[LOW_W-1:0] = cur[IDX_RND][LOW_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= req.en && !idx_legal(req.idx);
    end

    assign idx_err    = err_q;
    assign pend_flags = {pvld[2], pvld[1], pvld[0]};
    assign pend_mod   = pdata[IDX_MOD];
    assign pend_acc   = pdata[IDX_ACC];

    // R9: illegal write flags an error next cycle
    p_bad_write_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 2'd3) |=> idx_err);

    // R9: error only after an illegal write
    p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
        idx_err |-> $past(wr_en && wr_idx == 2'd3));

    // R9: an illegal write creates no pending state
    p_bad_write_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == 2'd3 && pend_flags == 3'b000) |=> pend_flags == 3'b000);

    // R6: the random entry never goes pending
    p_rnd_no_pend_r6: assert property (@(posedge clk) disable iff (rst)
        !pend_flags[1]);

    // R7: low word view matches the random entry
    p_rnd32_r7: assert property (@(posedge clk) disable iff (rst)
        rd_idx == 2'd1 |-> rd_rnd32 == rd_data[31:0]);
endmodule

// File: tb/test_wsr_file.sv
module test_wsr_file;
    localparam int W = 256;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    rd_idx;
    logic [W-1:0]  rd_data;
    logic [31:0]   rd_rnd32;
    logic          wr_en;
    logic [1:0]    wr_idx;
    logic [W-1:0]  wr_data;
    logic          commit;
    logic          abort;
    logic [2:0]    pend_flags;
    logic [W-1:0]  pend_mod;
    logic [W-1:0]  pend_acc;
    logic          idx_err;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [W-1:0] m_val [3];
    logic [W-1:0] m_pd  [3];
    logic         m_pv  [3];
    logic         m_err;

    always #2 clk = ~clk;

    wsr_file #(.DATA_W(W), .RND_NIB(4'h9)) i_wsr_file (
        .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_rnd32(rd_rnd32), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .commit(commit), .abort(abort),
        .pend_flags(pend_flags), .pend_mod(pend_mod),
        .pend_acc(pend_acc), .idx_err(idx_err)
    );

    function automatic logic [W-1:0] rnd_pat();
        logic [W-1:0] p;
        for (int n = 0; n < W/4; n++) p[n*4 +: 4] = 4'h9;
        return p;
    endfunction

    function automatic logic [W-1:0] exp_read(input logic [1:0] idx);
        case (idx)
            2'd0:    return m_val[0];
            2'd1:    return rnd_pat();
            2'd2:    return m_val[2];
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < 3; i++) begin
                m_val[i] = '0; m_pd[i] = '0; m_pv[i] = 1'b0;
            end
            m_err = 1'b0;
        end else begin
            m_err = wr_en && wr_idx == 2'd3;
            if (abort) begin
                for (int i = 0; i < 3; i++) m_pv[i] = 1'b0;
            end else begin
                for (int i = 0; i < 3; i += 2) begin
                    if (commit && m_pv[i]) begin
                        m_val[i] = m_pd[i]; m_pv[i] = 1'b0;
                    end
                    if (wr_en && wr_idx == 2'(i)) begin
                        m_pd[i] = wr_data; m_pv[i] = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic check_all();
        chk("R2 R3 R6 R9 read port", rd_data, exp_read(rd_idx));
        chk("R7 low word", W'(rd_rnd32), W'(32'h99999999));
        chk("R3 R6 pending flags", W'(pend_flags), W'({m_pv[2], 1'b0, m_pv[0]}));
        chk("R3 R8 staged modulus", pend_mod, m_pv[0] ? m_pd[0] : '0);
        chk("R3 R8 staged accumulator", pend_acc, m_pv[2] ? m_pd[2] : '0);
        chk("R9 error pulse", W'(idx_err), W'(m_err));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        check_all();
        @(negedge clk);
    endtask

    task automatic drive(input logic we, input logic [1:0] wi, input logic [W-1:0] wd,
                         input logic c, input logic a, input logic [1:0] ri);
        wr_en = we; wr_idx = wi; wr_data = wd; commit = c; abort = a; rd_idx = ri;
        step();
    endtask

    function automatic logic [W-1:0] rword();
        logic [W-1:0] v;
        for (int k = 0; k < W/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [W-1:0] a, b;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; wr_en = 0; wr_idx = 0; wr_data = '0; commit = 0; abort = 0; rd_idx = 0;
        @(negedge clk);
        step();
        // R1: reset state
        chk("R1 modulus after reset", rd_data, '0);
        rd_idx = 2'd2; #1;
        chk("R1 accumulator after reset", rd_data, '0);
        chk("R1 no pending after reset", W'(pend_flags), '0);
        chk("R1 error low after reset", W'(idx_err), '0);
        rst = 1'b0;

        a = rword(); b = rword();
        // R3: staged write invisible until commit
        drive(1, 2'd0, a, 0, 0, 2'd0);
        chk("R3 modulus unchanged while pending", rd_data, '0);
        // R8: second write replaces
        drive(1, 2'd0, b, 0, 0, 2'd0);
        chk("R8 replaced staged value", pend_mod, b);
        // R4: commit loads, write in same cycle stays pending
        drive(1, 2'd2, a, 1, 0, 2'd0);
        chk("R4 modulus committed", rd_data, b);
        chk("R4 same-cycle write still pending", W'(pend_flags), W'(3'b100));
        // R5: abort beats commit
        drive(0, 2'd0, '0, 1, 1, 2'd2);
        chk("R5 abort over commit keeps accumulator", rd_data, '0);
        chk("R5 pending cleared", W'(pend_flags), '0);
        // R5: write during abort dropped
        drive(1, 2'd2, b, 0, 1, 2'd2);
        chk("R5 write under abort dropped", W'(pend_flags), '0);
        // R6: write to random entry ignored
        drive(1, 2'd1, a, 0, 0, 2'd1);
        drive(0, 2'd0, '0, 1, 0, 2'd1);
        chk("R6 random entry unchanged", rd_data, rnd_pat());
        // R9: illegal write, one-cycle pulse
        drive(1, 2'd3, a, 0, 0, 2'd3);
        chk("R9 error after illegal write", W'(idx_err), W'(1));
        chk("R9 illegal read zero", rd_data, '0);
        drive(0, 2'd0, '0, 0, 0, 2'd0);
        chk("R9 error lasts one cycle", W'(idx_err), '0);

        for (int n = 0; n < 600; n++) begin
            drive(($urandom % 3) != 0, 2'($urandom % 4), rword(),
                  ($urandom % 4) == 0, ($urandom % 10) == 0, 2'($urandom % 4));
        end
        rst = 1'b1;
        drive(0, 2'd0, '0, 0, 0, 2'd2);
        chk("R1 reset after traffic", rd_data, '0);
        rst = 1'b0;
        done = 1;
        summary();
    end
endmodule